// File: doc/BRIEF.md
# Writeback Slot Reservation Table

One execution lane often carries several functional units that finish after different numbers of cycles, for example a one-cycle adder, a two-cycle shifter and a three-cycle load path. All of them share one result bus, which is both the writeback path and the bypass path. If two instructions finish in the same cycle, they collide on that bus. This block prevents the collision at issue time. It keeps a table with one bit for each upcoming cycle. A request that names its latency is granted only when the bit for the cycle it would finish in is free.

The select stage raises a request with the latency code of the instruction it picked for the lane. In the same cycle the block answers with a grant or a denial. A granted request books its finishing cycle. A denied instruction does not issue in that cycle, and that issue slot is lost. The window moves one cycle closer every clock. The bit for the current cycle is presented as a busy indication for the result bus. A flush drops every booking.

Top module: `wb_resv_sb`

## Requirements
- R1: After synchronous reset, `wb_busy_o` is 0 and no cycle is booked, so a legal request issued right after reset is granted.
- R2: If `req_valid_i` is 1, `req_lat_i` is a legal latency (1 to MAX_LAT), the target slot is free and `flush_i` is 0, then `grant_o` is 1 and `deny_o` is 0 in that same cycle.
- R3: A grant with latency L in cycle t drives `wb_busy_o` to 1 in cycle t+L, unless a flush occurs before then.
- R4: A request whose finishing cycle is already booked gets `deny_o`=1 and `grant_o`=0, and it books nothing.
- R5: The window moves one slot per clock. A booking made with latency L in cycle t blocks a request of latency L-k in cycle t+k. A request that lands in any other cycle is unaffected.
- R6: A request with latency code 0 or above MAX_LAT is denied and books nothing.
- R7: `flush_i`=1 denies any request in that cycle and clears every booking, so `wb_busy_o` is 0 from the next cycle until a new grant lands.
- R8: With `req_valid_i`=0, both `grant_o` and `deny_o` are 0. `deny_o` is never 1 together with `grant_o`.
- R9: Under mixed traffic, `wb_busy_o` is 1 in exactly those cycles in which a granted, unflushed request's result lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Select stage asks to issue one instruction to this lane |
| req_lat_i | input | LAT_W | Latency of that instruction in cycles |
| flush_i | input | 1 | Drop all bookings; refuse this cycle's request |
| grant_o | output | 1 | Request accepted; its finishing cycle is now booked |
| deny_o | output | 1 | Request refused because of a conflict, an illegal latency or a flush |
| wb_busy_o | output | 1 | The result bus carries a booked writeback in this cycle |

## Verification
On every cycle, the assertions check that a grant and a denial never appear together, and that both are absent when there is no request. They also check that illegal latencies and flushes never produce a grant, that a flush leaves the bus idle in the next cycle, and that a one-cycle grant shows up as busy on the next cycle. One case of the window shifting is also checked every cycle: a two-cycle grant followed by a one-cycle request. Whether busy appears several cycles later at exactly the right distance, and whether a flush erases a booking that lies deep in the window, can only be shown by the bench scenarios. The same holds for matching long runs of mixed traffic against an independent cycle-indexed calendar.

// File: rtl/wbrs_pkg.sv
`timescale 1ns/1ps
package wbrs_pkg;
  // number of table slots needed for a given largest latency (index 0 = now)
  function automatic int unsigned slot_depth(input int unsigned max_lat);
    return max_lat + 1;
  endfunction
endpackage

// File: rtl/wbrs_lat_decode.sv
`timescale 1ns/1ps
module wbrs_lat_decode #(
  parameter int unsigned LAT_W = 3,
  parameter int unsigned DEPTH = 5
) (
  input  logic [LAT_W-1:0] lat_i,
  output logic [DEPTH-1:0] sel_o,
  output logic             legal_o
);
  // one-hot of the target slot; slot 0 (latency 0) is never selectable
  for (genvar k = 0; k < DEPTH; k++) begin : g_sel
    if (k == 0) begin : g_zero
      assign sel_o[k] = 1'b0;
    end else begin : g_cmp
      assign sel_o[k] = (lat_i == LAT_W'(k));
    end
  end
  assign legal_o = |sel_o;
endmodule

// File: rtl/wbrs_slot_table.sv
`timescale 1ns/1ps
module wbrs_slot_table #(
  parameter int unsigned DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [DEPTH-1:0] book_i,
  output logic [DEPTH-1:0] slots_o
);
  logic [DEPTH-1:0] slots_q;

  // new booking joins the table and everything moves one slot toward "now"
  always_ff @(posedge clk) begin
    if (rst || clear_i) slots_q <= '0;
    else                slots_q <= (slots_q | book_i) >> 1;
  end

  assign slots_o = slots_q;
endmodule

// File: rtl/wb_resv_sb.sv
`timescale 1ns/1ps
module wb_resv_sb #(
  parameter int unsigned MAX_LAT = 4,
  parameter int unsigned LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid_i,
  input  logic [LAT_W-1:0] req_lat_i,
  input  logic             flush_i,
  output logic             grant_o,
  output logic             deny_o,
  output logic             wb_busy_o
);
  localparam int unsigned DEPTH = wbrs_pkg::slot_depth(MAX_LAT);

  logic [DEPTH-1:0] sel;
  logic [DEPTH-1:0] slots;
  logic [DEPTH-1:0] book;
  logic             legal;
  logic             hit;
  logic             grant;

  wbrs_lat_decode #(.LAT_W(LAT_W), .DEPTH(DEPTH)) u_dec (
    .lat_i  (req_lat_i),
    .sel_o  (sel),
    .legal_o(legal)
  );

  assign hit   = |(slots & sel);
  assign grant = req_valid_i && legal && !hit && !flush_i && !rst;
  assign book  = grant ? sel : '0;

  wbrs_slot_table #(.DEPTH(DEPTH)) u_tbl (
    .clk    (clk),
    .rst    (rst),
    .clear_i(flush_i),
    .book_i (book),
    .slots_o(slots)
  );

  assign grant_o   = grant;
  assign deny_o    = req_valid_i && !grant;
  assign wb_busy_o = slots[0];
endmodule

// File: rtl/wb_resv_sb_chk.sv
`timescale 1ns/1ps
module wb_resv_sb_chk #(
  parameter int unsigned MAX_LAT = 4,
  parameter int unsigned LAT_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid_i,
  input logic [LAT_W-1:0] req_lat_i,
  input logic             flush_i,
  input logic             grant_o,
  input logic             deny_o,
  input logic             wb_busy_o
);
  // R8
  excl_answer_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && deny_o));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |-> (!grant_o && !deny_o));
  // R6
  bad_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && (req_lat_i == '0 || req_lat_i > LAT_W'(MAX_LAT))) |-> deny_o);
  // R7
  flush_deny_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |-> !grant_o);
  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !wb_busy_o);
  // R3
  lat1_land_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o && req_lat_i == LAT_W'(1)) |=> wb_busy_o);
  // R5
  shift_block_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_lat_i == LAT_W'(1) && $past(grant_o)
     && $past(req_lat_i) == LAT_W'(2)) |-> deny_o);
endmodule

bind wb_resv_sb wb_resv_sb_chk #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_chk (.*);

// File: tb/sim_wb_resv_sb.sv
`timescale 1ns/1ps
module sim_wb_resv_sb;
  localparam int unsigned MAX_LAT = 4;
  localparam int unsigned LAT_W   = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid_i = 1'b0;
  logic [LAT_W-1:0] req_lat_i = '0;
  logic             flush_i = 1'b0;
  logic             grant_o, deny_o, wb_busy_o;

  always #2.5 clk = ~clk;

  wb_resv_sb #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u0 (.*);

  typedef struct {
    logic  g;
    logic  d;
    logic  b;
    string tag;
  } exp_t;

  exp_t expq[$];
  bit   booked [0:4095];
  int   cyc = 0;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;

  // driver: apply one cycle of stimulus and predict the answer from a calendar
  task automatic step(input logic v, input int lat, input logic fl, input string tag);
    exp_t e;
    bit   legal;
    @(negedge clk);
    req_valid_i = v;
    req_lat_i   = LAT_W'(lat);
    flush_i     = fl;
    legal = (lat >= 1) && (lat <= MAX_LAT);
    e.g   = v && legal && !fl && !booked[cyc + lat];
    e.d   = v && !e.g;
    e.b   = booked[cyc];
    e.tag = tag;
    expq.push_back(e);
    if (fl) for (int k = cyc + 1; k <= cyc + MAX_LAT + 1; k++) booked[k] = 1'b0;
    if (e.g) booked[cyc + lat] = 1'b1;
    cyc++;
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        tests++;
        if (grant_o !== e.g || deny_o !== e.d || wb_busy_o !== e.b) begin
          fails++;
          $display("FAIL %s: got grant=%b deny=%b busy=%b exp grant=%b deny=%b busy=%b",
                   e.tag, grant_o, deny_o, wb_busy_o, e.g, e.d, e.b);
        end
      end
    end
  end

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < 4096; i++) booked[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, "R1");
    step(1, 1, 0, "R2");       // lands next cycle
    step(0, 0, 0, "R3");       // busy here
    step(1, 3, 0, "R2");
    step(0, 0, 0, "R8");
    step(0, 0, 0, "R3");
    step(0, 0, 0, "R3");       // busy from lat3
    step(1, 2, 0, "R2");       // books t+2
    step(1, 1, 0, "R5");       // same landing -> deny
    step(1, 2, 0, "R5");       // lands a cycle later -> grant
    step(1, 1, 0, "R4");       // collides with previous lat2
    step(0, 0, 0, "R3");
    step(1, 4, 0, "R2");
    step(1, 4, 0, "R2");
    step(1, 3, 0, "R4");       // collides with second lat4
    step(1, 0, 0, "R6");
    step(1, 5, 0, "R6");
    step(1, 7, 0, "R6");
    step(0, 0, 0, "R6");       // nothing booked by illegal codes
    step(1, 4, 0, "R2");
    step(0, 0, 1, "R7");       // flush drops it
    step(1, 2, 0, "R7");       // would have collided, now free
    step(1, 1, 1, "R7");       // flush refuses request
    step(0, 0, 0, "R7");
    step(0, 0, 0, "R7");
    lfsr = 8'h5a;
    for (int n = 0; n < 120; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[1], int'(lfsr[4:2]) % 6, (lfsr[7:5] == 3'b111) && lfsr[0], "R9");
    end
    for (int n = 0; n < 6; n++) step(0, 0, 0, "R9");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule